// File: doc/BRIEF.md
# Golomb Run-Length Test Decompressor

This block expands a Golomb-coded serial stream back into scan test data on chip. Every decoded run is a string of zeros closed by a single one. The group size M is a compile-time power of two, and each tail is TW = log2(M) bits wide. A code word is a unary prefix followed by a binary tail. The prefix holds one `1` for each complete group of M zeros, and a `0` closes it. The tail gives the number of zeros that remain inside the last group.

The tester offers a code bit on `bit_in` together with `bit_vld`. The decoder takes the bit only in a cycle where it holds `en` high. Decoded bits appear on `out_bit` in the cycles where `out_v` is high. While output is being produced, `en` stays low, which holds the tester off. The design is a four-state machine (PREFIX, ZEROS, TAIL, EMIT), one shared log2(M)-bit counter with a completion flag, and a tail register.

The state transitions are as follows:
- PREFIX goes to ZEROS when it accepts a 1.
- PREFIX goes to TAIL when it accepts a 0.
- ZEROS goes back to PREFIX when the counter reports completion after M output cycles.
- TAIL goes to EMIT when it accepts the last tail bit.
- EMIT goes to PREFIX in the cycle it emits the closing one.

Top module: `golomb_decomp`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the decoder is in PREFIX with `en`=1 and `out_v`=0.
- R2: A prefix `1` accepted at a clock edge produces exactly M cycles of `out_v`=1 with `out_bit`=0, starting at the next edge. `en` is 0 throughout those M cycles and returns to 1 after them.
- R3: An accepted `0` in PREFIX is the separator. It produces no output, and in the following cycle `en` is 1 and `out_v` is 0 (tail collection).
- R4: The TW tail bits are taken MSB first. After the last tail bit, the decoder emits as many zeros as the tail's binary value, then one `1`, one bit per cycle starting at the next edge, with `en`=0 throughout.
- R5: `out_v` is 1 exactly in the cycles where a decompressed bit is present, and `en` is the complement of `out_v`.
- R6: A cycle with `en`=1 and `bit_vld`=0 leaves the decoder unchanged. Its outputs stay `en`=1 and `out_v`=0.
- R7: With M=4 the code words decode as: `000` to run 0, `011` to run 3, `1000` to run 4, `1011` to run 7, `11000` to run 8, and `11011` to run 11. Here a run of L is L zeros followed by a 1.
- R8: A tail value of zero makes the decoder emit only the closing `1`, in a single output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Code bit offered by the tester |
| bit_vld | input | 1 | `bit_in` holds a code bit this cycle |
| en | output | 1 | Decoder accepts a code bit this cycle |
| out_bit | output | 1 | Decompressed data bit |
| out_v | output | 1 | `out_bit` is valid |

## Verification
The fixed code words for M=4 are each checked against the expected run. These words show apart a missing prefix group, a reversed tail bit order and a wrong zero count. A tail of zero covers the single-cycle emit path. A separator followed by a long stall shows that prefix decoding has ended without any output. Random run sequences that include runs of many groups are then fed with dense and with heavy input stalls. A behavioural model checks `en`, `out_v` and `out_bit` on every cycle, which shows apart wrong stall handling and off-by-one group lengths.

// File: rtl/golomb_pkg.sv
package golomb_pkg;
    typedef enum logic [1:0] {
        ST_PREFIX = 2'd0,
        ST_ZEROS  = 2'd1,
        ST_TAIL   = 2'd2,
        ST_EMIT   = 2'd3
    } gdec_state_t;
endpackage

// File: rtl/golomb_cnt.sv
module golomb_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] lim,
    output logic         rs
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign rs = (cnt == lim);
endmodule

// File: rtl/golomb_tail.sv
module golomb_tail #(
    parameter int TW = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic shift,
    input  logic bit_in,
    input  logic dec,
    output logic zero
);
    logic [TW-1:0] val;

    always_ff @(posedge clk) begin
        if (rst || clr)  val <= '0;
        else if (shift)  val <= (val << 1) | TW'(bit_in);
        else if (dec)    val <= val - 1'b1;
    end

    assign zero = (val == '0);
endmodule

// File: rtl/golomb_decomp.sv
module golomb_decomp
    import golomb_pkg::*;
#(
    parameter int M = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    output logic en,
    output logic out_bit,
    output logic out_v
);
    localparam int TW = (M > 2) ? $clog2(M) : 1;
    localparam logic [TW-1:0] LIM_ZEROS = TW'(M - 1);
    localparam logic [TW-1:0] LIM_TAIL  = TW'(TW - 1);

    gdec_state_t state, state_nx;
    logic        accept, rs, tail_zero;
    logic        cnt_clr, cnt_inc;
    logic [TW-1:0] cnt_lim;

    initial begin
        if (M < 2 || (M & (M - 1)) != 0) $error("M must be a power of two >= 2");
    end

    assign accept = en && bit_vld;

    // shared counter: zero count in ZEROS, tail bit index in TAIL
    assign cnt_clr = (state == ST_PREFIX);
    assign cnt_inc = (state == ST_ZEROS) || ((state == ST_TAIL) && accept);
    assign cnt_lim = (state == ST_ZEROS) ? LIM_ZEROS : LIM_TAIL;

    golomb_cnt #(.W(TW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .lim (cnt_lim),
        .rs  (rs)
    );

    golomb_tail #(.TW(TW)) u_tail (
        .clk    (clk),
        .rst    (rst),
        .clr    (state == ST_PREFIX),
        .shift  ((state == ST_TAIL) && accept),
        .bit_in (bit_in),
        .dec    ((state == ST_EMIT) && !tail_zero),
        .zero   (tail_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_PREFIX;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PREFIX: if (accept) state_nx = bit_in ? ST_ZEROS : ST_TAIL;
            ST_ZEROS:  if (rs) state_nx = ST_PREFIX;
            ST_TAIL:   if (accept && rs) state_nx = ST_EMIT;
            ST_EMIT:   if (tail_zero) state_nx = ST_PREFIX;
            default:   state_nx = ST_PREFIX;
        endcase
    end

    // outputs
    always_comb begin
        en      = 1'b0;
        out_v   = 1'b0;
        out_bit = 1'b0;
        unique case (state)
            ST_PREFIX: en = 1'b1;
            ST_TAIL:   en = 1'b1;
            ST_ZEROS:  out_v = 1'b1;
            ST_EMIT: begin
                out_v   = 1'b1;
                out_bit = tail_zero;
            end
            default: en = 1'b0;
        endcase
    end

    // R5: handshake sides never overlap
    p_en_v_excl_r5: assert property (@(posedge clk) disable iff (rst)
        en != out_v);

    // R2: a prefix one starts a group of zeros
    p_prefix_one_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PREFIX && accept && bit_in) |=> (out_v && !out_bit && !en));

    // R2: group of zeros is not cut short before the counter completes
    p_zeros_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ZEROS && !rs) |=> (state == ST_ZEROS));

    // R3: separator produces no output and opens tail collection
    p_separator_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PREFIX && accept && !bit_in) |=> (state == ST_TAIL && en && !out_v));

    // R4: the closing one returns the decoder to prefix decoding
    p_emit_end_r4: assert property (@(posedge clk) disable iff (rst)
        (out_v && out_bit) |=> (state == ST_PREFIX && en));

    // R6: no offered bit, no change
    p_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !bit_vld) |=> ($stable(state) && en && !out_v));
endmodule

// File: tb/golomb_decomp_tb.sv
module golomb_decomp_tb;
    localparam int M  = 4;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic en, out_bit, out_v;

    always #4 clk = ~clk;

    golomb_decomp #(.M(M)) u_dut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
        .en(en), .out_bit(out_bit), .out_v(out_v)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit timeout = 1'b0;

    // behavioural model state
    int  pz = 0;        // zeros still to be output
    bit  po = 1'b0;     // closing one still to be output
    bit  in_tail = 1'b0;
    int  tbits = 0;
    int  tval = 0;
    bit  last_acc = 1'b0;
    bit  got[$];

    function automatic bit busy();
        return (pz > 0) || po;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(en === !busy(), "R2", en, !busy());
        chk(out_v === busy(), "R5", out_v, busy());
        if (busy()) begin
            chk(out_bit === ((pz > 0) ? 1'b0 : 1'b1), "R4", out_bit, (pz > 0) ? 0 : 1);
        end
        if (out_v === 1'b1) got.push_back(out_bit);
    endtask

    task automatic model_update(input bit vld, input bit b);
        last_acc = 1'b0;
        if (busy()) begin
            if (pz > 0) pz--;
            else po = 1'b0;
        end else if (vld) begin
            last_acc = 1'b1;
            if (!in_tail) begin
                if (b) pz = M;
                else begin in_tail = 1'b1; tbits = 0; tval = 0; end
            end else begin
                tval = tval * 2 + b;
                tbits++;
                if (tbits == TW) begin pz = tval; po = 1'b1; in_tail = 1'b0; end
            end
        end
    endtask

    task automatic cycle(input bit vld, input bit b);
        @(negedge clk);
        check_outputs();
        bit_vld = vld;
        bit_in  = b;
        @(posedge clk);
        #1;
        model_update(vld, b);
        cyc++;
        if (cyc > 150000) timeout = 1'b1;
    endtask

    task automatic run_seg(input int runs[$], input int stall_pct, input string req);
        bit code[$];
        bit exp[$];
        got.delete();
        foreach (runs[i]) begin
            for (int k = 0; k < runs[i] / M; k++) code.push_back(1'b1);
            code.push_back(1'b0);
            for (int j = TW - 1; j >= 0; j--) code.push_back(((runs[i] % M) >> j) & 1);
            for (int z = 0; z < runs[i]; z++) exp.push_back(1'b0);
            exp.push_back(1'b1);
        end
        while ((code.size() > 0 || busy() || in_tail) && !timeout) begin
            bit v;
            v = (code.size() > 0) && (($urandom % 100) >= stall_pct);
            cycle(v, (code.size() > 0) ? code[0] : 1'b0);
            if (last_acc) void'(code.pop_front());
        end
        cycle(1'b0, 1'b0);
        chk(got.size() == exp.size(), req, got.size(), exp.size());
        if (got.size() == exp.size()) begin
            int bad = 0;
            foreach (exp[i]) if (got[i] != exp[i]) bad++;
            chk(bad == 0, req, bad, 0);
        end
    endtask

    initial begin
        int rq[$];
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(en === 1'b1 && out_v === 1'b0, "R1", {en, out_v}, 2);
        rst = 1'b0;
        @(negedge clk);
        chk(en === 1'b1 && out_v === 1'b0, "R1", {en, out_v}, 2);

        // R7: fixed code words for M=4
        rq = '{0}; run_seg(rq, 0, "R7");
        rq = '{3}; run_seg(rq, 0, "R7");
        rq = '{4}; run_seg(rq, 0, "R7");
        rq = '{7}; run_seg(rq, 0, "R7");
        rq = '{8}; run_seg(rq, 0, "R7");
        rq = '{11}; run_seg(rq, 0, "R7");
        // R8: back-to-back zero tails
        rq = '{0, 0, 0}; run_seg(rq, 0, "R8");
        // R2: many prefix groups
        rq = '{17, 25, 1}; run_seg(rq, 0, "R2");

        // R3: separator then stall
        cycle(1'b1, 1'b0);
        for (int s = 0; s < 3; s++) begin
            cycle(1'b0, 1'b0);
            chk(en === 1'b1 && out_v === 1'b0, "R3", {en, out_v}, 2);
        end
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b0);
        repeat (4) cycle(1'b0, 1'b0);
        // R6: long idle in prefix state
        for (int s = 0; s < 5; s++) begin
            cycle(1'b0, 1'b1);
            chk(en === 1'b1 && out_v === 1'b0, "R6", {en, out_v}, 2);
        end

        // R4/R6: random runs with stalls
        for (int p = 0; p < 6 && !timeout; p++) begin
            rq.delete();
            for (int n = 0; n < 40; n++)
                rq.push_back(($urandom % 4 == 0) ? int'($urandom % 40) : int'($urandom % 6));
            run_seg(rq, (p % 2) ? 60 : 10, (p % 2) ? "R6" : "R4");
        end

        if (timeout) chk(1'b0, "watchdog", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule